// File: doc/BRIEF.md
# Display Controller Instruction and Address Engine

This block sits between a host bus interface and the scan logic of a dot-matrix display driver. Each transfer is an 8-bit byte with two qualifiers: instruction or data, and read or write. Instruction writes are decoded into control register updates or address changes. Instruction reads return a status byte. Data transfers read or write a display memory of 80 columns by 4 pages of 8 bits, which gives 32 display rows. After each access the column pointer moves forward.

The control registers are display on, start line, column direction, static drive and duty. They drive the scan block directly, and a separate combinational port lets the scan block fetch any memory byte. Data reads go through a one-byte prefetch latch, so the host sees a dummy byte first after any address change. A read-modify-write mode stops reads from moving the column pointer. A soft reset instruction clears the addresses and then holds the block busy for a fixed number of cycles.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: After `rst_n` is sampled low, all outputs are zero: `disp_on`, `start_line`, `adc_rev`, `static_drive`, `duty_32` and `rdata`. The page and column addresses are also 0.
- R2: Four instruction families take their value from bit 0 of the instruction byte. `1010111x` sets `disp_on` to x. `1010000x` sets `adc_rev` to x (1 = reverse). `1010010x` sets `static_drive` to x. `1010100x` sets `duty_32` to x (1 = 1/32 duty, 0 = 1/16 duty).
- R3: The instruction `110nnnnn` loads `start_line` with the 5-bit value n.
- R4: `101110pp` loads the page address with pp. An instruction with bit 7 clear loads the column address from bits 6..0. Values above 79 are clamped to 79.
- R5: A data write stores the byte at the current page and column, then increments the column. The column holds at 79 once it reaches 79, so further writes overwrite column 79.
- R6: A data read returns the contents of a prefetch latch, loads the latch from the current page and column, and increments the column. The latch reads 0x00 after a page set, a column set, the soft reset instruction or a data write.
- R7: `11100000` enters read-modify-write mode. In this mode data reads leave the column unchanged and data writes still advance it. `11101110` leaves the mode.
- R8: An instruction read returns a status byte. Bit 7 is busy, bit 6 is 1 for forward direction, bit 5 is 1 when the display is off, bit 4 is 1 while resetting, and bits 3..0 are 0.
- R9: `11100010` clears `start_line`, the page and the column. It then holds busy and resetting for RESET_CYCLES cycles. During that time every transfer except a status read is ignored.
- R10: Instruction codes outside the families above change no register and no address.
- R11: `scan_data` returns the stored byte at `scan_page`/`scan_col` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_valid | input | 1 | One-cycle transfer strobe |
| xfer_data | input | 1 | 1 = data transfer, 0 = instruction/status |
| xfer_read | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read result, valid after the accepting edge |
| disp_on | output | 1 | Display enabled |
| start_line | output | 5 | Row shown at the top of the panel |
| adc_rev | output | 1 | Column-to-segment order reversed |
| static_drive | output | 1 | Static drive selected |
| duty_32 | output | 1 | 1/32 duty selected (else 1/16) |
| scan_page | input | 2 | Scan read page |
| scan_col | input | 7 | Scan read column |
| scan_data | output | 8 | Scan read byte |

## Verification
Assertions check the following on every cycle: the column stays in range, writes and normal reads advance the column, reads in read-modify-write mode hold it, the soft reset raises busy and clears the start line, and the low status nibble is zero. Some behaviour can only be shown by the bench's transfer sequences and their read-back values. This covers the dummy byte, data coming back through the prefetch latch, the clamp and saturation at column 79, undefined codes having no effect, and transfers being dropped while busy.

// File: rtl/lcd_cmd_pkg.sv
// Package: shared decoded-instruction type for the display controller.
// Assumes all instruction formats are 8 bits wide.
package lcd_cmd_pkg;
    typedef enum logic [3:0] {
        OP_NONE,
        OP_DISP,
        OP_START,
        OP_PAGE,
        OP_COL,
        OP_ADC,
        OP_STATIC,
        OP_DUTY,
        OP_RMW_ON,
        OP_RMW_OFF,
        OP_SRESET
    } op_e;
endpackage

// File: rtl/lcd_instr_decode.sv
// Module: combinational instruction classifier.
// Splits an 8-bit instruction into an operation and its argument fields.
// Assumes nothing about timing; unknown codes map to OP_NONE.
module lcd_instr_decode
    import lcd_cmd_pkg::*;
(
    input  logic [7:0] code,
    output op_e        op,
    output logic [4:0] line_arg,
    output logic [1:0] page_arg,
    output logic [6:0] col_arg,
    output logic       flag_arg
);
    // field extraction is fixed by the instruction formats
    assign line_arg = code[4:0];
    assign page_arg = code[1:0];
    assign col_arg  = code[6:0];
    assign flag_arg = code[0];

    // classify the opcode; anything unmatched is ignored downstream
    always_comb begin
        casez (code)
            8'b0???_????: op = OP_COL;
            8'b1010_111?: op = OP_DISP;
            8'b110?_????: op = OP_START;
            8'b1011_10??: op = OP_PAGE;
            8'b1010_000?: op = OP_ADC;
            8'b1010_010?: op = OP_STATIC;
            8'b1010_100?: op = OP_DUTY;
            8'b1110_0000: op = OP_RMW_ON;
            8'b1110_1110: op = OP_RMW_OFF;
            8'b1110_0010: op = OP_SRESET;
            default:      op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/lcd_ctrl_regs.sv
// Module: display control registers and soft-reset busy timer.
// Assumes instr_wr is already qualified with "not busy".
module lcd_ctrl_regs
    import lcd_cmd_pkg::*;
#(
    parameter int RESET_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       instr_wr,
    input  op_e        op,
    input  logic [4:0] line_arg,
    input  logic       flag_arg,
    output logic       disp_on,
    output logic [4:0] start_line,
    output logic       adc_rev,
    output logic       static_drive,
    output logic       duty_32,
    output logic       busy
);
    localparam int CNT_W = $clog2(RESET_CYCLES + 1);

    logic [CNT_W-1:0] busy_cnt;

    // load the single-bit mode registers and the start line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_on      <= 1'b0;
            start_line   <= '0;
            adc_rev      <= 1'b0;
            static_drive <= 1'b0;
            duty_32      <= 1'b0;
        end else if (instr_wr) begin
            case (op)
                OP_DISP:   disp_on      <= flag_arg;
                OP_START:  start_line   <= line_arg;
                OP_ADC:    adc_rev      <= flag_arg;
                OP_STATIC: static_drive <= flag_arg;
                OP_DUTY:   duty_32      <= flag_arg;
                OP_SRESET: start_line   <= '0;
                default:   ;
            endcase
        end
    end

    // count down the busy window opened by the soft reset instruction
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_cnt <= '0;
        else if (instr_wr && op == OP_SRESET)
            busy_cnt <= CNT_W'(RESET_CYCLES);
        else if (busy_cnt != '0)
            busy_cnt <= busy_cnt - 1'b1;
    end

    assign busy = (busy_cnt != '0);

    // R9: soft reset opens the busy window and clears the start line
    a_r9_reset_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_wr && op == OP_SRESET) |=> (busy && start_line == 5'd0));

    // R9: no accepted instruction can occur while busy is set
    a_r9_no_instr_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !instr_wr);
endmodule

// File: rtl/lcd_addr_ctrl.sv
// Module: page/column pointer, read-modify-write mode and read prefetch latch.
// Assumes the strobes are already qualified with "not busy" and that the
// memory read port returns the byte at (page, col) combinationally.
module lcd_addr_ctrl
    import lcd_cmd_pkg::*;
#(
    parameter int COLS  = 80,
    parameter int PAGES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      instr_wr,
    input  logic                      data_wr,
    input  logic                      data_rd,
    input  op_e                       op,
    input  logic [1:0]                page_arg,
    input  logic [6:0]                col_arg,
    input  logic [7:0]                ram_q,
    output logic [$clog2(PAGES)-1:0]  page,
    output logic [$clog2(COLS)-1:0]   col,
    output logic                      rmw,
    output logic [7:0]                rd_latch
);
    localparam int PAGE_W  = $clog2(PAGES);
    localparam int COL_W   = $clog2(COLS);
    localparam int COL_MAX = COLS - 1;

    logic [COL_W-1:0] col_inc;
    logic [COL_W-1:0] col_set;

    // saturating increment and clamped column load value
    assign col_inc = (int'(col) >= COL_MAX) ? COL_W'(COL_MAX) : col + COL_W'(1);
    assign col_set = (int'(col_arg) > COL_MAX) ? COL_W'(COL_MAX) : COL_W'(col_arg);

    // page and column pointer updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
            col  <= '0;
        end else if (instr_wr) begin
            case (op)
                OP_PAGE:   page <= page_arg[PAGE_W-1:0];
                OP_COL:    col  <= col_set;
                OP_SRESET: begin
                    page <= '0;
                    col  <= '0;
                end
                default: ;
            endcase
        end else if (data_wr || (data_rd && !rmw)) begin
            col <= col_inc;
        end
    end

    // read-modify-write mode flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            rmw <= 1'b0;
        else if (instr_wr && op == OP_RMW_ON)
            rmw <= 1'b1;
        else if (instr_wr && op == OP_RMW_OFF)
            rmw <= 1'b0;
    end

    // prefetch latch: filled on reads, emptied when the address or data changes
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_latch <= 8'h00;
        else if (data_rd)
            rd_latch <= ram_q;
        else if (data_wr)
            rd_latch <= 8'h00;
        else if (instr_wr && (op == OP_PAGE || op == OP_COL || op == OP_SRESET))
            rd_latch <= 8'h00;
    end

    // R4: the column pointer never leaves the valid range
    a_r4_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(col) <= COL_MAX);

    // R5: a data write below the last column moves the column on by one
    a_r5_write_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && int'(col) < COL_MAX) |=> (col == $past(col) + COL_W'(1)));

    // R6: a normal data read below the last column moves the column on by one
    a_r6_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rmw && int'(col) < COL_MAX) |=> (col == $past(col) + COL_W'(1)));

    // R7: reads in read-modify-write mode leave the column alone
    a_r7_rmw_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rmw) |=> $stable(col));
endmodule

// File: rtl/lcd_dram.sv
// Module: display memory, one write port, one controller read port and one
// scan read port. Assumes the controller never presents a column >= COLS;
// the scan port returns 0 for such a column.
module lcd_dram #(
    parameter int COLS  = 80,
    parameter int PAGES = 4
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(PAGES)-1:0] wr_page,
    input  logic [$clog2(COLS)-1:0]  wr_col,
    input  logic [7:0]               wdata,
    output logic [7:0]               rd_q,
    input  logic [$clog2(PAGES)-1:0] scan_page,
    input  logic [$clog2(COLS)-1:0]  scan_col,
    output logic [7:0]               scan_q
);
    localparam int DEPTH  = COLS * PAGES;
    localparam int ADDR_W = $clog2(DEPTH);

    logic [7:0]        mem [DEPTH];
    logic [ADDR_W-1:0] ctl_idx;
    logic [ADDR_W-1:0] scan_idx;

    assign ctl_idx  = ADDR_W'(int'(wr_page) * COLS + int'(wr_col));
    assign scan_idx = ADDR_W'(int'(scan_page) * COLS + int'(scan_col));

    // store a byte at the controller address
    always_ff @(posedge clk) begin
        if (we)
            mem[ctl_idx] <= wdata;
    end

    assign rd_q   = mem[ctl_idx];
    assign scan_q = (int'(scan_col) < COLS) ? mem[scan_idx] : 8'h00;
endmodule

// File: rtl/lcd_cmd_decoder.sv
// Module: top of the display controller instruction/address engine.
// Qualifies host transfers, builds the status byte and registers the read
// result. Assumes xfer_valid is a one-cycle strobe per transfer.
module lcd_cmd_decoder
    import lcd_cmd_pkg::*;
#(
    parameter int COLS         = 80,
    parameter int PAGES        = 4,
    parameter int RESET_CYCLES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     xfer_valid,
    input  logic                     xfer_data,
    input  logic                     xfer_read,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata,
    output logic                     disp_on,
    output logic [4:0]               start_line,
    output logic                     adc_rev,
    output logic                     static_drive,
    output logic                     duty_32,
    input  logic [$clog2(PAGES)-1:0] scan_page,
    input  logic [$clog2(COLS)-1:0]  scan_col,
    output logic [7:0]               scan_data
);
    localparam int PAGE_W = $clog2(PAGES);
    localparam int COL_W  = $clog2(COLS);

    op_e              op;
    logic [4:0]       line_arg;
    logic [1:0]       page_arg;
    logic [6:0]       col_arg;
    logic             flag_arg;
    logic             busy;
    logic             instr_wr, data_wr, data_rd, stat_rd;
    logic [PAGE_W-1:0] page;
    logic [COL_W-1:0]  col;
    logic             rmw;
    logic [7:0]       rd_latch;
    logic [7:0]       ram_q;
    logic [7:0]       status;

    // transfer qualification: only status reads pass while busy
    assign instr_wr = xfer_valid && !busy && !xfer_data && !xfer_read;
    assign data_wr  = xfer_valid && !busy &&  xfer_data && !xfer_read;
    assign data_rd  = xfer_valid && !busy &&  xfer_data &&  xfer_read;
    assign stat_rd  = xfer_valid && !xfer_data && xfer_read;

    assign status = {busy, !adc_rev, !disp_on, busy, 4'b0000};

    lcd_instr_decode u_dec (
        .code     (wdata),
        .op       (op),
        .line_arg (line_arg),
        .page_arg (page_arg),
        .col_arg  (col_arg),
        .flag_arg (flag_arg)
    );

    lcd_ctrl_regs #(.RESET_CYCLES(RESET_CYCLES)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_wr     (instr_wr),
        .op           (op),
        .line_arg     (line_arg),
        .flag_arg     (flag_arg),
        .disp_on      (disp_on),
        .start_line   (start_line),
        .adc_rev      (adc_rev),
        .static_drive (static_drive),
        .duty_32      (duty_32),
        .busy         (busy)
    );

    lcd_addr_ctrl #(.COLS(COLS), .PAGES(PAGES)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr_wr (instr_wr),
        .data_wr  (data_wr),
        .data_rd  (data_rd),
        .op       (op),
        .page_arg (page_arg),
        .col_arg  (col_arg),
        .ram_q    (ram_q),
        .page     (page),
        .col      (col),
        .rmw      (rmw),
        .rd_latch (rd_latch)
    );

    lcd_dram #(.COLS(COLS), .PAGES(PAGES)) u_ram (
        .clk       (clk),
        .we        (data_wr),
        .wr_page   (page),
        .wr_col    (col),
        .wdata     (wdata),
        .rd_q      (ram_q),
        .scan_page (scan_page),
        .scan_col  (scan_col),
        .scan_q    (scan_data)
    );

    // register the byte returned to the host
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= 8'h00;
        else if (stat_rd)
            rdata <= status;
        else if (data_rd)
            rdata <= rd_latch;
    end

    // R8: the low status nibble always reads zero
    a_r8_status_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (rdata[3:0] == 4'h0));

    // R8: busy and resetting flags travel together in the status byte
    a_r8_status_flags: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (rdata[7] == rdata[4]));
endmodule

// File: tb/lcd_cmd_decoder_test.sv
module lcd_cmd_decoder_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       dat;
        logic       rd;
        logic [7:0] val;
        logic       chk;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 30;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 8'h00, 1'b1, 8'h60, 4'd8},   // R8 status after reset
        '{1'b0, 1'b0, 8'hAF, 1'b0, 8'h00, 4'd2},   // display on
        '{1'b0, 1'b1, 8'h00, 1'b1, 8'h40, 4'd2},   // R2 on in status
        '{1'b0, 1'b0, 8'hA1, 1'b0, 8'h00, 4'd2},   // reverse
        '{1'b0, 1'b1, 8'h00, 1'b1, 8'h00, 4'd2},   // R2 reverse in status
        '{1'b0, 1'b0, 8'hA0, 1'b0, 8'h00, 4'd2},
        '{1'b0, 1'b0, 8'hB9, 1'b0, 8'h00, 4'd4},   // page 1
        '{1'b0, 1'b0, 8'h05, 1'b0, 8'h00, 4'd4},   // col 5
        '{1'b1, 1'b0, 8'h3C, 1'b0, 8'h00, 4'd5},
        '{1'b1, 1'b0, 8'h5A, 1'b0, 8'h00, 4'd5},
        '{1'b0, 1'b0, 8'h05, 1'b0, 8'h00, 4'd4},
        '{1'b1, 1'b1, 8'h00, 1'b1, 8'h00, 4'd6},   // R6 dummy
        '{1'b1, 1'b1, 8'h00, 1'b1, 8'h3C, 4'd6},   // R6 col5
        '{1'b1, 1'b1, 8'h00, 1'b1, 8'h5A, 4'd6},   // R6 col6
        '{1'b0, 1'b0, 8'h05, 1'b0, 8'h00, 4'd4},
        '{1'b0, 1'b0, 8'hE0, 1'b0, 8'h00, 4'd7},   // rmw on
        '{1'b1, 1'b1, 8'h00, 1'b1, 8'h00, 4'd7},   // R7 dummy
        '{1'b1, 1'b1, 8'h00, 1'b1, 8'h3C, 4'd7},   // R7 col5
        '{1'b1, 1'b1, 8'h00, 1'b1, 8'h3C, 4'd7},   // R7 still col5
        '{1'b1, 1'b0, 8'h77, 1'b0, 8'h00, 4'd7},   // write col5, go col6
        '{1'b1, 1'b1, 8'h00, 1'b1, 8'h00, 4'd7},   // R7 dummy after write
        '{1'b1, 1'b1, 8'h00, 1'b1, 8'h5A, 4'd7},   // R7 col6
        '{1'b0, 1'b0, 8'hEE, 1'b0, 8'h00, 4'd7},   // rmw off
        '{1'b1, 1'b1, 8'h00, 1'b1, 8'h5A, 4'd7},   // R7 col6, advances now
        '{1'b0, 1'b0, 8'hFF, 1'b0, 8'h00, 4'd10},  // undefined
        '{1'b0, 1'b0, 8'hB4, 1'b0, 8'h00, 4'd10},  // undefined
        '{1'b0, 1'b1, 8'h00, 1'b1, 8'h40, 4'd10},  // R10 status unchanged
        '{1'b0, 1'b0, 8'h05, 1'b0, 8'h00, 4'd10},
        '{1'b1, 1'b1, 8'h00, 1'b1, 8'h00, 4'd10},  // R10 dummy
        '{1'b1, 1'b1, 8'h00, 1'b1, 8'h77, 4'd10}   // R10 page still 1
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_valid = 1'b0;
    logic       xfer_data = 1'b0;
    logic       xfer_read = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       disp_on, adc_rev, static_drive, duty_32;
    logic [4:0] start_line;
    logic [1:0] scan_page = 2'd0;
    logic [6:0] scan_col = 7'd0;
    logic [7:0] scan_data;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcd_cmd_decoder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_valid   (xfer_valid),
        .xfer_data    (xfer_data),
        .xfer_read    (xfer_read),
        .wdata        (wdata),
        .rdata        (rdata),
        .disp_on      (disp_on),
        .start_line   (start_line),
        .adc_rev      (adc_rev),
        .static_drive (static_drive),
        .duty_32      (duty_32),
        .scan_page    (scan_page),
        .scan_col     (scan_col),
        .scan_data    (scan_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one transfer: accepted at the posedge, result sampled at the next negedge
    task automatic xfer(input logic dat, input logic rd, input logic [7:0] val);
        @(negedge clk);
        xfer_valid = 1'b1;
        xfer_data  = dat;
        xfer_read  = rd;
        wdata      = val;
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    task automatic scan(input logic [1:0] p, input logic [6:0] c, output logic [7:0] q);
        scan_page = p;
        scan_col  = c;
        #1;
        q = scan_data;
    endtask

    initial begin
        logic [7:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 disp_on", {7'b0, disp_on}, 8'h00);
        check("R1 start_line", {3'b0, start_line}, 8'h00);
        check("R1 adc/static/duty", {5'b0, adc_rev, static_drive, duty_32}, 8'h00);
        check("R1 rdata", rdata, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            xfer(VECS[i].dat, VECS[i].rd, VECS[i].val);
            if (VECS[i].chk)
                check($sformatf("R%0d vec%0d", VECS[i].req, i), rdata, VECS[i].exp);
        end

        // R2 and R3 register outputs
        xfer(1'b0, 1'b0, 8'hA5);
        xfer(1'b0, 1'b0, 8'hA9);
        xfer(1'b0, 1'b0, 8'hD3);
        check("R2 static on", {7'b0, static_drive}, 8'h01);
        check("R2 duty 1/32", {7'b0, duty_32}, 8'h01);
        check("R3 start 19", {3'b0, start_line}, 8'd19);
        xfer(1'b0, 1'b0, 8'hA4);
        xfer(1'b0, 1'b0, 8'hDF);
        check("R2 static off", {7'b0, static_drive}, 8'h00);
        check("R3 start 31", {3'b0, start_line}, 8'd31);

        // R5 saturation at the last column
        xfer(1'b0, 1'b0, 8'hBA);
        xfer(1'b0, 1'b0, 8'h4E);
        xfer(1'b1, 1'b0, 8'hAA);
        xfer(1'b1, 1'b0, 8'hBB);
        xfer(1'b1, 1'b0, 8'hCC);
        scan(2'd2, 7'd78, q); check("R5 col78", q, 8'hAA);
        scan(2'd2, 7'd79, q); check("R5 col79 saturate", q, 8'hCC);
        // R4 column clamp
        xfer(1'b0, 1'b0, 8'h7F);
        xfer(1'b1, 1'b0, 8'h11);
        scan(2'd2, 7'd79, q); check("R4 clamp to 79", q, 8'h11);
        scan(2'd2, 7'd78, q); check("R4 col78 untouched", q, 8'hAA);
        // R11 scan port
        scan(2'd1, 7'd5, q); check("R11 scan p1c5", q, 8'h77);
        scan(2'd1, 7'd6, q); check("R11 scan p1c6", q, 8'h5A);

        // R9 soft reset
        xfer(1'b0, 1'b0, 8'hB8);
        xfer(1'b0, 1'b0, 8'h00);
        xfer(1'b1, 1'b0, 8'h99);
        xfer(1'b0, 1'b0, 8'hBB);
        xfer(1'b0, 1'b0, 8'h0A);
        xfer(1'b0, 1'b0, 8'hE2);
        xfer(1'b0, 1'b1, 8'h00);
        check("R9 busy status", rdata, 8'hD0);
        xfer(1'b1, 1'b0, 8'h55);
        xfer(1'b0, 1'b0, 8'hAE);
        repeat (10) @(negedge clk);
        xfer(1'b0, 1'b1, 8'h00);
        check("R9 ready status, display still on", rdata, 8'h40);
        check("R9 start cleared", {3'b0, start_line}, 8'h00);
        scan(2'd0, 7'd0, q); check("R9 write dropped while busy", q, 8'h99);
        xfer(1'b1, 1'b0, 8'h66);
        scan(2'd0, 7'd0, q); check("R9 page and column cleared", q, 8'h66);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule